// File: doc/BRIEF.md
# Power-State-Aware Watchdog Timer

This block is a watchdog made of a base tick counter followed by a programmable postscaler. Every `2^BASE_W` enabled ticks the base counter advances the postscaler. When the postscaler reaches the ratio picked by `ps_sel_i`, the chain expires. What an expiry means depends on the processor's power state when it happens. While the core executes code (run), the expiry requests a watchdog reset. While the core is halted (idle or sleep), the expiry becomes a wake request instead.

Several events clear both stages together, on any clock edge and whether or not a tick is present:
- a clear-watchdog instruction strobe;
- a sleep instruction strobe;
- a loss of the selected clock, but only when the fail-safe clock monitor is enabled;
- a write to the internal oscillator frequency select, but only when the internal oscillator drives the system.

A clear that lands on the same edge as an expiry cancels that expiry. Clock generation and the reset controller sit outside the block. The block only issues single-cycle requests to them.

Top module: `wdt_mode_guard`

## Requirements
- R1: With `pwr_state_i` = 2'b00 (run), an expiry raises `wdt_rst_o` for one cycle and leaves `wake_o` low. The expiry happens on the edge that carries the N-th tick after a clear, where N = 2^BASE_W * 2^`ps_sel_i`. The output is high right after that edge.
- R2: With `pwr_state_i` = 2'b01 (idle), 2'b10 (sleep) or 2'b11 (also halted), an expiry raises `wake_o` for one cycle and leaves `wdt_rst_o` low.
- R3: The postscaler ratio is 2^`ps_sel_i`, for every value of the `PS_SEL_W`-bit select, from 1:1 up to 1:2^(2^PS_SEL_W - 1).
- R4: Only clock edges with `tick_i` high advance the chain. The expiry needs N ticks, however many idle cycles come between them.
- R5: A `clr_wdt_i` pulse zeroes the base counter and the postscaler. The next expiry then comes N ticks after the clearing edge.
- R6: A `sleep_exec_i` pulse zeroes both stages in the same way.
- R7: `clk_lost_i` zeroes both stages when `fscm_en_i` is high. It has no effect when `fscm_en_i` is low.
- R8: `osc_sel_wr_i` zeroes both stages when `intosc_sys_i` is high. It has no effect when `intosc_sys_i` is low.
- R9: After each expiry the chain restarts from zero. Without any clear, the next expiry follows exactly N ticks later, and each request lasts one cycle.
- R10: A clear on the same edge as an expiry wins. No reset or wake request is issued for that expiry, and the next one comes N ticks later.
- R11: While `rst_ni` is low, both outputs are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Watchdog tick enable |
| ps_sel_i | input | PS_SEL_W | Postscaler ratio exponent |
| pwr_state_i | input | 2 | 00 run, 01 idle, 10 sleep, 11 halted |
| clr_wdt_i | input | 1 | Clear-watchdog instruction strobe |
| sleep_exec_i | input | 1 | Sleep instruction strobe |
| clk_lost_i | input | 1 | Selected clock has failed |
| fscm_en_i | input | 1 | Fail-safe clock monitor enabled |
| osc_sel_wr_i | input | 1 | Internal oscillator frequency-select write strobe |
| intosc_sys_i | input | 1 | Internal oscillator is the system clock |
| wdt_rst_o | output | 1 | Watchdog reset request, one cycle |
| wake_o | output | 1 | Wake request, one cycle |

## Verification
The bench builds the block with BASE_W = 2 and PS_SEL_W = 3. The longest period is then 4 x 128 = 512 ticks, so the bench can sweep every ratio select against every power state and measure each period tick by tick. This small configuration also makes it cheap to place each clear source and its gate at chosen tick positions, including the exact expiry edge. Sparse tick patterns and back-to-back expiries with no clear in between check the tick gating and the restart from zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PWR_RUN   = 2'b00,
    PWR_IDLE  = 2'b01,
    PWR_SLEEP = 2'b10,
    PWR_HALT  = 2'b11
  } pwr_state_e;

  function automatic logic is_executing(input logic [1:0] st);
    return pwr_state_e'(st) == PWR_RUN;
  endfunction
endpackage

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl (
  input  logic clr_wdt_i,
  input  logic sleep_exec_i,
  input  logic clk_lost_i,
  input  logic fscm_en_i,
  input  logic osc_sel_wr_i,
  input  logic intosc_sys_i,
  output logic clr_o
);
  logic [3:0] src;

  always_comb begin
    src[0] = clr_wdt_i;
    src[1] = sleep_exec_i;
    src[2] = clk_lost_i & fscm_en_i;
    src[3] = osc_sel_wr_i & intosc_sys_i;
    clr_o  = |src;
  end
endmodule

// File: rtl/wdt_base_ctr.sv
module wdt_base_ctr #(
  parameter int BASE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic carry_o
);
  localparam logic [BASE_W-1:0] CNT_MAX = {BASE_W{1'b1}};

  logic [BASE_W-1:0] cnt_q;

  // wraps to zero naturally at CNT_MAX
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign carry_o = tick_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tmo_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // limit = 2^sel - 1
  always_comb begin
    limit = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(sel_i)) limit[i] = 1'b1;
    end
  end

  // >= keeps a lowered ratio from running past its limit
  assign tmo_o = step_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tmo_o)  cnt_q <= '0;
    else if (step_i)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tmo_i,
  input  logic       clr_i,
  input  logic [1:0] pwr_state_i,
  output logic       wdt_rst_o,
  output logic       wake_o
);
  logic fire;
  logic exec;

  assign fire = tmo_i & ~clr_i;
  assign exec = is_executing(pwr_state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_rst_o <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      wdt_rst_o <= fire & exec;
      wake_o    <= fire & ~exec;
    end
  end
endmodule

// File: rtl/wdt_mode_guard.sv
module wdt_mode_guard #(
  parameter int BASE_W   = 8,
  parameter int PS_SEL_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [PS_SEL_W-1:0] ps_sel_i,
  input  logic [1:0]          pwr_state_i,
  input  logic                clr_wdt_i,
  input  logic                sleep_exec_i,
  input  logic                clk_lost_i,
  input  logic                fscm_en_i,
  input  logic                osc_sel_wr_i,
  input  logic                intosc_sys_i,
  output logic                wdt_rst_o,
  output logic                wake_o
);
  logic clr;
  logic carry;
  logic tmo;

  wdt_clear_ctl u_clr (
    .clr_wdt_i    (clr_wdt_i),
    .sleep_exec_i (sleep_exec_i),
    .clk_lost_i   (clk_lost_i),
    .fscm_en_i    (fscm_en_i),
    .osc_sel_wr_i (osc_sel_wr_i),
    .intosc_sys_i (intosc_sys_i),
    .clr_o        (clr)
  );

  wdt_base_ctr #(.BASE_W(BASE_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clr_i   (clr),
    .carry_o (carry)
  );

  wdt_postscaler #(.SEL_W(PS_SEL_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (carry),
    .clr_i  (clr),
    .sel_i  (ps_sel_i),
    .tmo_o  (tmo)
  );

  wdt_action u_act (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmo_i       (tmo),
    .clr_i       (clr),
    .pwr_state_i (pwr_state_i),
    .wdt_rst_o   (wdt_rst_o),
    .wake_o      (wake_o)
  );
endmodule

// File: rtl/wdt_mode_guard_chk.sv
module wdt_mode_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [1:0] pwr_state_i,
  input logic       clr_wdt_i,
  input logic       sleep_exec_i,
  input logic       clk_lost_i,
  input logic       fscm_en_i,
  input logic       osc_sel_wr_i,
  input logic       intosc_sys_i,
  input logic       wdt_rst_o,
  input logic       wake_o
);
  logic any_clr;
  assign any_clr = clr_wdt_i | sleep_exec_i | (clk_lost_i & fscm_en_i)
                 | (osc_sel_wr_i & intosc_sys_i);

  a_r1_reset_only_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(pwr_state_i) == 2'b00);

  a_r2_wake_only_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(pwr_state_i) != 2'b00);

  a_r2_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_rst_o && wake_o));

  a_r4_no_expiry_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> !wdt_rst_o && !wake_o);

  a_r9_rst_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  a_r9_wake_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(any_clr) |-> !wdt_rst_o && !wake_o);

  always_comb begin
    if (!rst_ni) a_r11_quiet_in_reset: assert (!wdt_rst_o && !wake_o);
  end
endmodule

bind wdt_mode_guard wdt_mode_guard_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .pwr_state_i  (pwr_state_i),
  .clr_wdt_i    (clr_wdt_i),
  .sleep_exec_i (sleep_exec_i),
  .clk_lost_i   (clk_lost_i),
  .fscm_en_i    (fscm_en_i),
  .osc_sel_wr_i (osc_sel_wr_i),
  .intosc_sys_i (intosc_sys_i),
  .wdt_rst_o    (wdt_rst_o),
  .wake_o       (wake_o)
);

// File: tb/sim_wdt_mode_guard.sv
`timescale 1ns/1ps
module sim_wdt_mode_guard;
  localparam int BASE_W   = 2;
  localparam int PS_SEL_W = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic [PS_SEL_W-1:0] ps_sel_i = '0;
  logic [1:0] pwr_state_i = 2'b00;
  logic clr_wdt_i = 0, sleep_exec_i = 0, clk_lost_i = 0, fscm_en_i = 0;
  logic osc_sel_wr_i = 0, intosc_sys_i = 0;
  logic wdt_rst_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  wdt_mode_guard #(.BASE_W(BASE_W), .PS_SEL_W(PS_SEL_W)) u0 (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  // ev: 0 none, 1 clr_wdt, 2 sleep, 3 clk_lost+fscm, 4 clk_lost alone,
  //     5 osc write+intosc, 6 osc write alone
  // tmode: 0 tick every edge, 1 tick every third edge
  task automatic run_case(input int sel, input logic [1:0] st, input int pre,
                          input int ev, input bit exp_clr, input int tmode,
                          input string rq);
    int n;
    int ticks;
    int edges;
    int exp_t;
    bit got_rst;
    bit got_wake;
    bit seen;
    n = (1 << BASE_W) << sel;
    exp_t = exp_clr ? pre + 1 + n : n;
    @(negedge clk_i);
    ps_sel_i = sel[PS_SEL_W-1:0];
    pwr_state_i = st;
    tick_i = 1'b0;
    clr_wdt_i = 1'b1;
    @(negedge clk_i);
    clr_wdt_i = 1'b0;
    ticks = 0;
    edges = 0;
    seen = 0;
    got_rst = 0;
    got_wake = 0;
    while (!seen && edges < 4 * exp_t + 20) begin
      tick_i = (tmode == 0) || (edges % 3 == 0) || (ticks == pre);
      if (ticks == pre && tick_i) begin
        case (ev)
          1: clr_wdt_i = 1'b1;
          2: sleep_exec_i = 1'b1;
          3: begin clk_lost_i = 1'b1; fscm_en_i = 1'b1; end
          4: begin clk_lost_i = 1'b1; fscm_en_i = 1'b0; end
          5: begin osc_sel_wr_i = 1'b1; intosc_sys_i = 1'b1; end
          6: begin osc_sel_wr_i = 1'b1; intosc_sys_i = 1'b0; end
          default: ;
        endcase
      end
      @(posedge clk_i);
      if (tick_i) ticks++;
      edges++;
      @(negedge clk_i);
      clr_wdt_i = 0; sleep_exec_i = 0; clk_lost_i = 0; fscm_en_i = 0;
      osc_sel_wr_i = 0; intosc_sys_i = 0;
      if (wdt_rst_o || wake_o) begin
        seen = 1;
        got_rst = wdt_rst_o;
        got_wake = wake_o;
      end
    end
    chk(ticks == exp_t, rq, ticks, exp_t);
    if (st == 2'b00) chk(got_rst && !got_wake, "R1 reset in run", {got_rst, got_wake}, 2);
    else             chk(got_wake && !got_rst, "R2 wake when halted", {got_rst, got_wake}, 1);
    // R9: one-cycle pulse, then restart from zero
    tick_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!wdt_rst_o && !wake_o, "R9 single-cycle pulse", {wdt_rst_o, wake_o}, 0);
    ticks = 1;
    seen = 0;
    while (!seen && ticks < n + 10) begin
      @(posedge clk_i);
      ticks++;
      @(negedge clk_i);
      seen = wdt_rst_o || wake_o;
    end
    chk(ticks == n, "R9 restart period", ticks, n);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!wdt_rst_o && !wake_o, "R11 reset state", {wdt_rst_o, wake_o}, 0);
    rst_ni = 1'b1;
    // R1, R3: every ratio in run
    for (int s = 0; s < (1 << PS_SEL_W); s++) run_case(s, 2'b00, 0, 0, 0, 0, "R3 ratio run");
    // R2: halted states
    for (int s = 0; s < 4; s++) begin
      for (int st = 1; st < 4; st++) run_case(s, st[1:0], 0, 0, 0, 0, "R2 ratio halted");
    end
    // R4: sparse ticks
    run_case(1, 2'b00, 0, 0, 0, 1, "R4 sparse ticks");
    run_case(3, 2'b10, 0, 0, 0, 1, "R4 sparse ticks halted");
    // R5..R8 clear sources mid-count
    run_case(2, 2'b00, 9, 1, 1, 0, "R5 clr_wdt clears");
    run_case(2, 2'b00, 9, 2, 1, 0, "R6 sleep clears");
    run_case(2, 2'b00, 9, 3, 1, 0, "R7 clk loss with monitor clears");
    run_case(2, 2'b00, 9, 4, 0, 0, "R7 clk loss without monitor ignored");
    run_case(2, 2'b01, 9, 5, 1, 0, "R8 osc write on intosc clears");
    run_case(2, 2'b01, 9, 6, 0, 0, "R8 osc write off intosc ignored");
    run_case(0, 2'b00, 2, 3, 1, 1, "R7 clear under sparse ticks");
    // R10: clear on the expiry edge (tick N-1 counted before event edge)
    run_case(1, 2'b00, 7, 1, 1, 0, "R10 clear wins run");
    run_case(1, 2'b10, 7, 2, 1, 0, "R10 clear wins sleep");
    run_case(0, 2'b00, 3, 5, 1, 0, "R10 clear wins osc write");
    run_case(0, 2'b00, 3, 6, 0, 0, "R10 gated-off event does not cancel");
    // R11: reset mid-count
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!wdt_rst_o && !wake_o, "R11 reset mid-run", {wdt_rst_o, wake_o}, 0);
    rst_ni = 1'b1;
    finish_run();
  end
endmodule